// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This block decides where a 16-bit processor fetches its next instruction word. It takes the fetched instruction word, the address that word came from, and the four status flags: negative, zero, carry and overflow. It recognises the relative-jump instruction format and tests that instruction's 3-bit condition against the flags. It then drives a taken indication, the jump target and the resulting next fetch address.

A jump target is formed from the address of the following word plus a signed 10-bit displacement. The displacement counts 16-bit words, so it is doubled before it is added. When the word is not a jump, or its condition fails, the next fetch address is the sequential one. All address arithmetic wraps modulo the address width.

The parameter `REG_OUT` picks between a purely combinational result and a registered result. The registered result is captured on the rising clock edge and cleared by a synchronous active-high reset. The default build is registered, so every result appears one clock after its inputs are presented.

Top module: `branch_resolve`

## Requirements
- R1: A word whose bits 15..13 equal 3'b001 is a jump. `is_jump_o` is 1 for it and 0 for every other word, and `taken_o` is never 1 unless `is_jump_o` is 1.
- R2: Condition field (bits 12..10) 3'b000 is taken when Z is 0; 3'b001 is taken when Z is 1.
- R3: Condition 3'b010 is taken when C is 0; 3'b011 is taken when C is 1.
- R4: Condition 3'b100 is taken when N is 1.
- R5: Condition 3'b101 is taken when N equals V; 3'b110 is taken when N differs from V.
- R6: Condition 3'b111 is taken for every flag combination.
- R7: `target_o` equals PC + 2 + 2 × sext(bits 9..0) modulo 2^16, where bits 9..0 are a two's-complement word count. This covers +511, −512, 0 and −1, and wraparound past 0xFFFF or below 0x0000.
- R8: `next_pc_o` equals `target_o` when `taken_o` is 1. Otherwise it equals PC + 2 modulo 2^16.
- R9: For a word that is not a jump, `taken_o` is 0 and `next_pc_o` is PC + 2, whatever the flags and the low 13 bits hold.
- R10: With `REG_OUT`=1, results appear on the outputs one clock after their inputs are presented. A cycle with `rst` high clears `is_jump_o`, `taken_o`, `target_o` and `next_pc_o` to 0 at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered variant |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| instr_i | input | 16 | Fetched instruction word |
| pc_i | input | AW (16) | Address of the fetched word |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| is_jump_o | output | 1 | Word is in jump format |
| taken_o | output | 1 | Jump condition holds |
| target_o | output | AW (16) | Jump destination address |
| next_pc_o | output | AW (16) | Next fetch address |

## Verification
The assertions assume that the instruction word, address and flags have known values on every clock edge outside reset. They also assume that reset does not arrive between a word and its registered result; when it does, the affected checks are discarded. The bench changes all inputs once per cycle, just after the falling edge, and never leaves them undriven. Reset is applied only at the start and in one dedicated step, and in that step the bench expects the cleared outputs rather than a result.

// File: rtl/branch_resolve.sv
module branch_resolve #(
  parameter int AW      = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [15:0]   instr_i,
  input  logic [AW-1:0] pc_i,
  input  logic          flag_n,
  input  logic          flag_z,
  input  logic          flag_c,
  input  logic          flag_v,
  output logic          is_jump_o,
  output logic          taken_o,
  output logic [AW-1:0] target_o,
  output logic [AW-1:0] next_pc_o
);
  localparam int OFF_W = 10;
  localparam int EXT_W = AW - OFF_W - 1;
  localparam logic [2:0] JMP_GROUP = 3'b001;

  logic          jmp_fmt;
  logic [2:0]    cond;
  logic          cond_ok;
  logic          take;
  logic [AW-1:0] seq_pc;
  logic [AW-1:0] disp;
  logic [AW-1:0] dest;
  logic [AW-1:0] nxt;

  assign jmp_fmt = (instr_i[15:13] == JMP_GROUP);
  assign cond    = instr_i[12:10];
  assign seq_pc  = pc_i + AW'(2);
  assign disp    = {{EXT_W{instr_i[OFF_W-1]}}, instr_i[OFF_W-1:0], 1'b0};
  assign dest    = seq_pc + disp;

  always_comb begin
    unique case (cond)
      3'd0: cond_ok = ~flag_z;
      3'd1: cond_ok =  flag_z;
      3'd2: cond_ok = ~flag_c;
      3'd3: cond_ok =  flag_c;
      3'd4: cond_ok =  flag_n;
      3'd5: cond_ok = ~(flag_n ^ flag_v);
      3'd6: cond_ok =  (flag_n ^ flag_v);
      default: cond_ok = 1'b1;
    endcase
  end

  assign take = jmp_fmt & cond_ok;
  assign nxt  = take ? dest : seq_pc;

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          is_jump_o <= 1'b0;
          taken_o   <= 1'b0;
          target_o  <= '0;
          next_pc_o <= '0;
        end else begin
          is_jump_o <= jmp_fmt;
          taken_o   <= take;
          target_o  <= dest;
          next_pc_o <= nxt;
        end
      end
    end else begin : g_comb
      assign is_jump_o = jmp_fmt;
      assign taken_o   = take;
      assign target_o  = dest;
      assign next_pc_o = nxt;
    end
  endgenerate
endmodule

// File: rtl/branch_resolve_chk.sv
module branch_resolve_chk #(
  parameter int AW      = 16,
  parameter bit REG_OUT = 1'b1
) (
  input logic          clk,
  input logic          rst,
  input logic [15:0]   instr_i,
  input logic [AW-1:0] pc_i,
  input logic          flag_n,
  input logic          flag_z,
  input logic          flag_c,
  input logic          flag_v,
  input logic          is_jump_o,
  input logic          taken_o,
  input logic [AW-1:0] target_o,
  input logic [AW-1:0] next_pc_o
);
  logic [AW-1:0] exp_disp;
  assign exp_disp = AW'($signed(instr_i[9:0])) <<< 1;

  assert_taken_implies_jump_R1: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> is_jump_o);

  assert_taken_uses_target_R8: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> (next_pc_o == target_o));

  generate
    if (REG_OUT) begin : g_seq
      assert_nonjump_sequential_R9: assert property (@(posedge clk) disable iff (rst)
        (instr_i[15:13] != 3'b001) |=> (!is_jump_o && !taken_o && next_pc_o == $past(pc_i) + AW'(2)));

      assert_zero_set_taken_R2: assert property (@(posedge clk) disable iff (rst)
        (instr_i[15:10] == 6'b001001 && flag_z) |=> taken_o);

      assert_carry_clear_taken_R3: assert property (@(posedge clk) disable iff (rst)
        (instr_i[15:10] == 6'b001010 && !flag_c) |=> taken_o);

      assert_negative_clear_not_taken_R4: assert property (@(posedge clk) disable iff (rst)
        (instr_i[15:10] == 6'b001100 && !flag_n) |=> !taken_o);

      assert_signed_less_R5: assert property (@(posedge clk) disable iff (rst)
        (instr_i[15:10] == 6'b001110 && (flag_n != flag_v)) |=> taken_o);

      assert_unconditional_R6: assert property (@(posedge clk) disable iff (rst)
        (instr_i[15:10] == 6'b001111) |=> taken_o);

      assert_target_math_R7: assert property (@(posedge clk) disable iff (rst)
        (instr_i[15:13] == 3'b001) |=> (target_o == $past(pc_i) + AW'(2) + $past(exp_disp)));

      assert_reset_clears_R10: assert property (@(posedge clk)
        $fell(rst) |-> (!is_jump_o && !taken_o && target_o == '0 && next_pc_o == '0));
    end else begin : g_cmb
      assert_nonjump_sequential_R9: assert property (@(posedge clk) disable iff (rst)
        (instr_i[15:13] != 3'b001) |-> (!taken_o && next_pc_o == pc_i + AW'(2)));

      assert_unconditional_R6: assert property (@(posedge clk) disable iff (rst)
        (instr_i[15:10] == 6'b001111) |-> taken_o);

      assert_target_math_R7: assert property (@(posedge clk) disable iff (rst)
        (instr_i[15:13] == 3'b001 && (flag_n | flag_z | flag_c | flag_v | 1'b1))
          |-> (target_o == pc_i + AW'(2) + exp_disp));
    end
  endgenerate
endmodule

bind branch_resolve branch_resolve_chk #(.AW(AW), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst(rst), .instr_i(instr_i), .pc_i(pc_i),
  .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
  .is_jump_o(is_jump_o), .taken_o(taken_o), .target_o(target_o), .next_pc_o(next_pc_o)
);

// File: tb/branch_resolve_test.sv
module branch_resolve_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] instr = 16'h0000;
  logic [15:0] pc = 16'h0000;
  logic        fn = 1'b0, fz = 1'b0, fc = 1'b0, fv = 1'b0;
  logic        is_jump, taken;
  logic [15:0] target, next_pc;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  branch_resolve #(.AW(16), .REG_OUT(1'b1)) uut (
    .clk(clk), .rst(rst), .instr_i(instr), .pc_i(pc),
    .flag_n(fn), .flag_z(fz), .flag_c(fc), .flag_v(fv),
    .is_jump_o(is_jump), .taken_o(taken), .target_o(target), .next_pc_o(next_pc)
  );

  function automatic bit cond_expect(input logic [2:0] c, input logic [3:0] f);
    logic n, z, cy, v;
    {n, z, cy, v} = f;
    case (c)
      3'd0: return z == 1'b0;
      3'd1: return z == 1'b1;
      3'd2: return cy == 1'b0;
      3'd3: return cy == 1'b1;
      3'd4: return n == 1'b1;
      3'd5: return n == v;
      3'd6: return n != v;
      default: return 1'b1;
    endcase
  endfunction

  function automatic string cond_tag(input logic [2:0] c);
    case (c)
      3'd0, 3'd1: return "R2";
      3'd2, 3'd3: return "R3";
      3'd4:       return "R4";
      3'd5, 3'd6: return "R5";
      default:    return "R6";
    endcase
  endfunction

  task automatic step(input logic [15:0] w, input logic [15:0] a, input logic [3:0] f, input string tag);
    logic jexp, texp;
    int off, tg;
    logic [15:0] tgexp, nexp;
    @(negedge clk);
    instr = w; pc = a; {fn, fz, fc, fv} = f;
    jexp  = (w[15:13] == 3'b001);
    off   = w[9] ? int'(w[9:0]) - 1024 : int'(w[9:0]);
    tg    = (int'(a) + 2 + 2 * off) % 65536;
    if (tg < 0) tg += 65536;
    tgexp = tg[15:0];
    texp  = jexp && cond_expect(w[12:10], f);
    nexp  = texp ? tgexp : 16'((int'(a) + 2) % 65536);
    @(posedge clk); #1;
    checks++;
    if (is_jump !== jexp || taken !== texp || next_pc !== nexp || (jexp && target !== tgexp)) begin
      fails++;
      $display("FAIL %s w=%h pc=%h f=%b: got j=%b t=%b tgt=%h nxt=%h exp j=%b t=%b tgt=%h nxt=%h",
               tag, w, a, f, is_jump, taken, target, next_pc, jexp, texp, tgexp, nexp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (is_jump !== 1'b0 || taken !== 1'b0 || target !== 16'h0 || next_pc !== 16'h0) begin
      fails++;
      $display("FAIL R10 reset: got j=%b t=%b tgt=%h nxt=%h exp 0 0 0000 0000", is_jump, taken, target, next_pc);
    end
    @(negedge clk); rst = 1'b0;

    for (int c = 0; c < 8; c++)
      for (int f = 0; f < 16; f++)
        step({3'b001, 3'(c), 10'((c * 37 + f * 61) % 1024)}, 16'(16'h1000 + c * 256 + f * 6), 4'(f), cond_tag(3'(c)));

    for (int c = 0; c < 8; c++) begin
      step({3'b001, 3'(c), 10'h1FF}, 16'hFC00, 4'b0000, "R7 +511 wrap");
      step({3'b001, 3'(c), 10'h200}, 16'h0100, 4'b1111, "R7 -512 wrap");
      step({3'b001, 3'(c), 10'h000}, 16'hFFFE, 4'b0101, "R7 zero wrap");
      step({3'b001, 3'(c), 10'h3FF}, 16'h0000, 4'b1010, "R7 -1");
      step({3'b001, 3'(c), 10'h3FF}, 16'hFFFE, 4'b0110, "R8 -1 wrap");
    end

    for (int g = 0; g < 8; g++) begin
      if (g == 1) continue;
      for (int f = 0; f < 16; f++)
        step({3'(g), 13'((g * 4099 + f * 977) % 8192)}, 16'(16'hFFF0 + f * 3), 4'(f), "R9 R1");
    end
    step(16'h4031, 16'hFFFE, 4'b0000, "R9 wrap");
    step(16'h3FFF, 16'h0002, 4'b0000, "R1 R6");

    @(negedge clk);
    instr = 16'h3C10; pc = 16'h2222; rst = 1'b1;
    @(posedge clk); #1;
    checks++;
    if (is_jump !== 1'b0 || taken !== 1'b0 || target !== 16'h0 || next_pc !== 16'h0) begin
      fails++;
      $display("FAIL R10 mid reset: got j=%b t=%b tgt=%h nxt=%h exp 0 0 0000 0000", is_jump, taken, target, next_pc);
    end
    @(negedge clk); rst = 1'b0;
    step(16'h3C10, 16'h2222, 4'b0000, "R10 after reset");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule